// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an addressing-mode code into the 16-bit effective address of an instruction operand, for a processor with 8-bit data and a 16-bit address space. The instruction sequencer gives it a start pulse along with the mode code, the address where the operand bytes begin, and the current values of the two index registers. The generator then fetches whatever operand and pointer bytes the mode needs over a single-byte synchronous read port and returns the address with a one-cycle done pulse.

The supported modes are immediate, direct page-zero (plain, X-indexed and Y-indexed), absolute (plain, X-indexed and Y-indexed), pre-indexed indirect through page zero and post-indexed indirect through page zero. Page-zero arithmetic stays inside page zero. Pointer fetches in page zero wrap within that page. Absolute and post-indexed sums wrap at the top of the 16-bit space. The no-operand code, and any code with no meaning, produces a one-cycle error pulse and no address.

A read address shown in one cycle has its data on `rd_data` in the next cycle. All mode inputs are latched when start is accepted. While the unit is busy, start is ignored.

Top module: `ea_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rd_en`, `busy`, `done` and `err` are 0 and `ea` is 0x0000.
- R2: Mode code 0 (immediate) makes no read and raises `done` in the cycle after start, with `ea` equal to the latched operand address.
- R3: Mode code 1 (page-zero direct) reads the operand address one cycle after start and raises `done` three cycles after start, with `ea` = {0x00, fetched byte}.
- R4: Mode codes 2 and 3 (page zero indexed by X or Y) time their reads as in R3. They give `ea` = {0x00, (byte + index) mod 256}, so the high byte of `ea` is always 0x00.
- R5: Mode code 4 (absolute) reads the operand address one cycle after start and the operand address + 1 (mod 65536) two cycles after start. It raises `done` four cycles after start, with `ea` = first byte | (second byte << 8).
- R6: Mode codes 5 and 6 (absolute indexed by X or Y) follow R5 and then add the zero-extended index modulo 65536.
- R7: Mode code 7 (pre-indexed indirect) reads the operand byte b one cycle after start. It then forms p = (b + X) mod 256 and reads {0x00, p} three cycles after start and {0x00, (p+1) mod 256} four cycles after start. It raises `done` six cycles after start, with `ea` = low | (high << 8).
- R8: Mode code 8 (post-indexed indirect) reads its bytes on the same schedule as R7, but p = b. It gives `ea` = ((high << 8) | low) + Y modulo 65536.
- R9: Mode code 9 and codes 10 to 15 make no read and raise `err` for one cycle in the cycle after start. `done` stays low.
- R10: `busy` is high from the cycle after an accepted start through the cycle of its `done` or `err`. A start while busy has no effect, and changes to the mode, operand address or index inputs after acceptance do not change the result.
- R11: `done` and `err` are single-cycle pulses that are never high together, and `ea` is 0x0000 whenever `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation (accepted only when not busy) |
| mode_code | input | 4 | Addressing-mode code |
| opnd_addr | input | 16 | Address of the first operand byte |
| idx_x | input | 8 | X index register value |
| idx_y | input | 8 | Y index register value |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: `ea` is valid |
| err | output | 1 | One-cycle pulse: mode has no operand address |
| ea | output | 16 | Effective address, valid with `done` |

## Verification
The assertions assume that memory returns the byte for each request in the following cycle and that start can arrive in any cycle, busy or not. They make no assumption about mode codes, so every code from 0 to 15 is legal stimulus. The bench provides a memory whose contents come from a hash of the address, with chosen bytes placed where the wrap cases need them. It drives inputs only between clock edges. It also pulses start and changes the mode and index inputs during a busy window on purpose, so that the latching and ignore behaviour is exercised.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;

    // Mode codes seen on the input port
    localparam logic [3:0] MC_IMM   = 4'd0;
    localparam logic [3:0] MC_ZP    = 4'd1;
    localparam logic [3:0] MC_ZPX   = 4'd2;
    localparam logic [3:0] MC_ZPY   = 4'd3;
    localparam logic [3:0] MC_ABS   = 4'd4;
    localparam logic [3:0] MC_ABSX  = 4'd5;
    localparam logic [3:0] MC_ABSY  = 4'd6;
    localparam logic [3:0] MC_PREIX = 4'd7;
    localparam logic [3:0] MC_POSIX = 4'd8;

    typedef enum logic [1:0] {
        IX_NONE = 2'd0,
        IX_X    = 2'd1,
        IX_Y    = 2'd2
    } idx_sel_e;

    // What a mode needs from the datapath
    typedef struct packed {
        logic     valid;     // mode forms an address
        logic     fetch;     // at least one operand byte is read
        logic     two_byte;  // operand is a 16-bit base
        logic     indirect;  // operand byte is a page-zero pointer
        logic     pre_x;     // X is added to the pointer before the fetch
        logic     zp_wrap;   // final add stays within page zero
        idx_sel_e final_idx; // index added after fetching
    } mode_attr_t;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_RD_OP0  = 4'd1,
        ST_RD_OP1  = 4'd2,
        ST_CAP_OP1 = 4'd3,
        ST_CAP_OP0 = 4'd4,
        ST_RD_PT0  = 4'd5,
        ST_RD_PT1  = 4'd6,
        ST_CAP_PT1 = 4'd7,
        ST_FIN     = 4'd8,
        ST_ERR     = 4'd9
    } seq_state_e;

    function automatic mode_attr_t attr_of(input logic [3:0] code);
        mode_attr_t a;
        a = '0;
        a.final_idx = IX_NONE;
        a.valid = 1'b1;
        case (code)
            MC_IMM:   ;
            MC_ZP:    begin a.fetch = 1'b1; a.zp_wrap = 1'b1; end
            MC_ZPX:   begin a.fetch = 1'b1; a.zp_wrap = 1'b1; a.final_idx = IX_X; end
            MC_ZPY:   begin a.fetch = 1'b1; a.zp_wrap = 1'b1; a.final_idx = IX_Y; end
            MC_ABS:   begin a.fetch = 1'b1; a.two_byte = 1'b1; end
            MC_ABSX:  begin a.fetch = 1'b1; a.two_byte = 1'b1; a.final_idx = IX_X; end
            MC_ABSY:  begin a.fetch = 1'b1; a.two_byte = 1'b1; a.final_idx = IX_Y; end
            MC_PREIX: begin a.fetch = 1'b1; a.indirect = 1'b1; a.pre_x = 1'b1; end
            MC_POSIX: begin a.fetch = 1'b1; a.indirect = 1'b1; a.final_idx = IX_Y; end
            default:  a.valid = 1'b0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
    import ea_gen_pkg::*;
(
    input  logic [3:0]  code,
    output mode_attr_t  attr
);
    always_comb attr = attr_of(code);
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_gen_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  mode_attr_t        attr,
    input  logic [AW-1:0]     opnd,
    input  logic [DW-1:0]     lo,
    input  logic [DW-1:0]     hi,
    input  logic [DW-1:0]     ix,
    input  logic [DW-1:0]     iy,
    output logic [AW-1:0]     addr
);
    localparam int HW = AW - DW;

    logic [DW-1:0] idx_b;
    logic [DW-1:0] page_sum;
    logic [AW-1:0] wide_base;
    logic [AW-1:0] wide_sum;

    always_comb begin
        case (attr.final_idx)
            IX_X:    idx_b = ix;
            IX_Y:    idx_b = iy;
            default: idx_b = '0;
        endcase
        page_sum  = lo + idx_b;
        wide_base = {hi[HW-1:0], lo};
        wide_sum  = wide_base + {{HW{1'b0}}, idx_b};
        if (!attr.fetch)
            addr = opnd;
        else if (attr.zp_wrap)
            addr = {{HW{1'b0}}, page_sum};
        else
            addr = wide_sum;
    end
endmodule

// File: rtl/ea_fetch_seq.sv
module ea_fetch_seq
    import ea_gen_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mode_attr_t        attr_in,
    input  logic [AW-1:0]     opnd_in,
    input  logic [DW-1:0]     x_in,
    input  logic [DW-1:0]     y_in,
    input  logic [DW-1:0]     rd_data,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    output logic              busy,
    output logic              fin,
    output logic              err,
    output mode_attr_t        attr_q,
    output logic [AW-1:0]     opnd_q,
    output logic [DW-1:0]     x_q,
    output logic [DW-1:0]     y_q,
    output logic [DW-1:0]     lo_q,
    output logic [DW-1:0]     hi_q
);
    localparam int HW = AW - DW;

    seq_state_e    state, nxt;
    logic [DW-1:0] ptr_q;
    logic [DW-1:0] ptr_next;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (start) begin
                if (!attr_in.valid)     nxt = ST_ERR;
                else if (attr_in.fetch) nxt = ST_RD_OP0;
                else                    nxt = ST_FIN;
            end
            ST_RD_OP0:  nxt = attr_q.two_byte ? ST_RD_OP1 : ST_CAP_OP0;
            ST_RD_OP1:  nxt = ST_CAP_OP1;
            ST_CAP_OP1: nxt = ST_FIN;
            ST_CAP_OP0: nxt = attr_q.indirect ? ST_RD_PT0 : ST_FIN;
            ST_RD_PT0:  nxt = ST_RD_PT1;
            ST_RD_PT1:  nxt = ST_CAP_PT1;
            ST_CAP_PT1: nxt = ST_FIN;
            ST_FIN:     nxt = ST_IDLE;
            ST_ERR:     nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_comb ptr_next = ptr_q + {{(DW-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            attr_q <= '0;
            opnd_q <= '0;
            x_q    <= '0;
            y_q    <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            ptr_q  <= '0;
        end else begin
            state <= nxt;
            case (state)
                ST_IDLE: if (start) begin
                    attr_q <= attr_in;
                    opnd_q <= opnd_in;
                    x_q    <= x_in;
                    y_q    <= y_in;
                    lo_q   <= '0;
                    hi_q   <= '0;
                end
                ST_RD_OP1:  lo_q <= rd_data;
                ST_CAP_OP1: hi_q <= rd_data;
                ST_CAP_OP0: begin
                    if (attr_q.indirect)
                        ptr_q <= rd_data + (attr_q.pre_x ? x_q : {DW{1'b0}});
                    else
                        lo_q <= rd_data;
                end
                ST_RD_PT1:  lo_q <= rd_data;
                ST_CAP_PT1: hi_q <= rd_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_en   = 1'b0;
        rd_addr = '0;
        case (state)
            ST_RD_OP0: begin rd_en = 1'b1; rd_addr = opnd_q; end
            ST_RD_OP1: begin rd_en = 1'b1; rd_addr = opnd_q + {{(AW-1){1'b0}}, 1'b1}; end
            ST_RD_PT0: begin rd_en = 1'b1; rd_addr = {{HW{1'b0}}, ptr_q}; end
            ST_RD_PT1: begin rd_en = 1'b1; rd_addr = {{HW{1'b0}}, ptr_next}; end
            default: ;
        endcase
    end

    assign busy = (state != ST_IDLE);
    assign fin  = (state == ST_FIN);
    assign err  = (state == ST_ERR);

    // Second operand byte comes from the address after the first (R5)
    assert_abs_next_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_OP1) |-> (rd_addr == $past(rd_addr) + {{(AW-1){1'b0}}, 1'b1}));

    // Pointer high byte is read in page zero right after the low byte (R7)
    assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_PT1) |-> (rd_addr[AW-1:DW] == '0 &&
            rd_addr[DW-1:0] == $past(rd_addr[DW-1:0]) + {{(DW-1){1'b0}}, 1'b1}));

    // Error follows an accepted start immediately (R9)
    assert_err_direct_R9: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(state) == ST_IDLE && !rd_en));

    // Latched operands hold while busy (R10)
    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(opnd_q) && $stable(x_q) && $stable(y_q) && $stable(attr_q)));
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_gen_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [3:0]    mode_code,
    input  logic [AW-1:0] opnd_addr,
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] ea
);
    mode_attr_t    attr_in, attr_q;
    logic [AW-1:0] opnd_q;
    logic [DW-1:0] x_q, y_q, lo_q, hi_q;
    logic [AW-1:0] calc_addr;
    logic          fin;

    ea_mode_decode u_dec (
        .code (mode_code),
        .attr (attr_in)
    );

    ea_fetch_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .attr_in (attr_in),
        .opnd_in (opnd_addr),
        .x_in    (idx_x),
        .y_in    (idx_y),
        .rd_data (rd_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .busy    (busy),
        .fin     (fin),
        .err     (err),
        .attr_q  (attr_q),
        .opnd_q  (opnd_q),
        .x_q     (x_q),
        .y_q     (y_q),
        .lo_q    (lo_q),
        .hi_q    (hi_q)
    );

    ea_addr_calc #(.AW(AW), .DW(DW)) u_calc (
        .attr (attr_q),
        .opnd (opnd_q),
        .lo   (lo_q),
        .hi   (hi_q),
        .ix   (x_q),
        .iy   (y_q),
        .addr (calc_addr)
    );

    assign done = fin;
    assign ea   = fin ? calc_addr : '0;

    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_ea_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !done |-> (ea == '0));

    assert_zp_page_R4: assert property (@(posedge clk) disable iff (rst)
        (done && attr_q.zp_wrap) |-> (ea[AW-1:DW] == '0));

    assert_imm_noread_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !attr_q.fetch) |-> ($past(busy) == 1'b0 && ea == $past(opnd_addr)));
endmodule

// File: tb/tb_ea_gen.sv
`timescale 1ns/1ps
module tb_ea_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode_code = '0;
    logic [15:0] opnd_addr = '0;
    logic [7:0]  idx_x = '0;
    logic [7:0]  idx_y = '0;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic        busy, done, err;
    logic [15:0] ea;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ea_gen dut (
        .clk(clk), .rst(rst), .start(start), .mode_code(mode_code),
        .opnd_addr(opnd_addr), .idx_x(idx_x), .idx_y(idx_y),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .err(err), .ea(ea)
    );

    // Memory contents: chosen bytes, else a hash of the address
    logic [7:0] ovr [int];

    function automatic logic [7:0] memf(input logic [15:0] a);
        if (ovr.exists(int'(a))) return ovr[int'(a)];
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_en) rd_data <= memf(rd_addr);
    end

    // Per-cycle expectation tables
    bit          e_rd   [int];
    logic [15:0] e_addr [int];
    bit          e_done [int];
    bit          e_err  [int];
    bit          e_busy [int];
    logic [15:0] e_ea   [int];
    string       e_tag  [int];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            string tag;
            bit xr, xd, xe, xb;
            logic [15:0] xa, xea;
            tag = rst ? "R1" : (e_tag.exists(cyc) ? e_tag[cyc] : "R11");
            xr  = e_rd.exists(cyc)   ? e_rd[cyc]   : 1'b0;
            xa  = e_addr.exists(cyc) ? e_addr[cyc] : 16'h0;
            xd  = e_done.exists(cyc) ? e_done[cyc] : 1'b0;
            xe  = e_err.exists(cyc)  ? e_err[cyc]  : 1'b0;
            xb  = e_busy.exists(cyc) ? e_busy[cyc] : 1'b0;
            xea = e_ea.exists(cyc)   ? e_ea[cyc]   : 16'h0;
            chk(tag, "rd_en", int'(rd_en), int'(xr));
            if (xr) chk(tag, "rd_addr", int'(rd_addr), int'(xa));
            chk(tag, "done", int'(done), int'(xd));
            chk(tag, "err", int'(err), int'(xe));
            chk(tag, "busy", int'(busy), int'(xb));
            chk(tag, "ea", int'(ea), xd ? int'(xea) : 0);
        end
    end

    // Expected schedule for a start accepted in cycle s
    task automatic sched(input int s, input logic [3:0] m, input logic [15:0] o,
                         input logic [7:0] x, input logic [7:0] y, input string tag,
                         output int len);
        logic [7:0]  b, p, p1, idx;
        logic [15:0] o1, base, res;
        bit bad;
        bad = 1'b0;
        res = 16'h0;
        o1  = o + 16'd1;
        idx = (m == 4'd2 || m == 4'd5) ? x : ((m == 4'd3 || m == 4'd6) ? y : 8'h00);
        case (m)
            4'd0: begin len = 1; res = o; end
            4'd1, 4'd2, 4'd3: begin
                len = 3;
                e_rd[s+1] = 1'b1; e_addr[s+1] = o;
                b = memf(o) + idx;
                res = {8'h00, b};
            end
            4'd4, 4'd5, 4'd6: begin
                len = 4;
                e_rd[s+1] = 1'b1; e_addr[s+1] = o;
                e_rd[s+2] = 1'b1; e_addr[s+2] = o1;
                base = {memf(o1), memf(o)};
                res = base + {8'h00, idx};
            end
            4'd7, 4'd8: begin
                len = 6;
                b  = memf(o);
                p  = (m == 4'd7) ? b + x : b;
                p1 = p + 8'd1;
                e_rd[s+1] = 1'b1; e_addr[s+1] = o;
                e_rd[s+3] = 1'b1; e_addr[s+3] = {8'h00, p};
                e_rd[s+4] = 1'b1; e_addr[s+4] = {8'h00, p1};
                base = {memf({8'h00, p1}), memf({8'h00, p})};
                res = base + ((m == 4'd8) ? {8'h00, y} : 16'h0);
            end
            default: begin len = 1; bad = 1'b1; end
        endcase
        for (int k = 1; k <= len; k++) begin
            e_busy[s+k] = 1'b1;
            e_tag[s+k]  = tag;
        end
        if (bad) e_err[s+len] = 1'b1;
        else begin
            e_done[s+len] = 1'b1;
            e_ea[s+len]   = res;
        end
    endtask

    task automatic issue(input logic [3:0] m, input logic [15:0] o,
                         input logic [7:0] x, input logic [7:0] y, input string tag);
        int s, len;
        @(negedge clk);
        start = 1'b1; mode_code = m; opnd_addr = o; idx_x = x; idx_y = y;
        s = cyc;
        sched(s, m, o, x, y, tag, len);
        @(negedge clk);
        start = 1'b0;
        repeat (len) @(negedge clk);
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finish");
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s, len;
        // memory bytes for the corner cases
        ovr[16'h8001] = 8'h44;
        ovr[16'h8010] = 8'hF0;
        ovr[16'h8011] = 8'h7F;
        ovr[16'h8020] = 8'hCD; ovr[16'h8021] = 8'hAB;
        ovr[16'hFFFF] = 8'h11; ovr[16'h0000] = 8'h22;
        ovr[16'h8030] = 8'hF0; ovr[16'h8031] = 8'hFF;
        ovr[16'h8040] = 8'h00; ovr[16'h8041] = 8'h12;
        ovr[16'h8050] = 8'hF0;
        ovr[16'h00FF] = 8'h34;
        ovr[16'h8060] = 8'h80;
        ovr[16'h0080] = 8'hF0; ovr[16'h0081] = 8'hFF;
        ovr[16'h8061] = 8'hFF;

        // R1: reset held for a few cycles, then released
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        issue(4'd0, 16'h1234, 8'h00, 8'h00, "R2");   // immediate
        issue(4'd0, 16'hFFFF, 8'h55, 8'h66, "R2");
        issue(4'd1, 16'h8001, 8'h00, 8'h00, "R3");   // page zero direct
        issue(4'd1, 16'h9ABC, 8'h10, 8'h20, "R3");
        issue(4'd2, 16'h8010, 8'h20, 8'h00, "R4");   // F0+20 wraps to 10
        issue(4'd3, 16'h8011, 8'h00, 8'h81, "R4");   // 7F+81 wraps to 00
        issue(4'd4, 16'h8020, 8'h00, 8'h00, "R5");   // little-endian ABCD
        issue(4'd4, 16'hFFFF, 8'h00, 8'h00, "R5");   // second byte at 0000
        issue(4'd5, 16'h8030, 8'h20, 8'h00, "R6");   // FFF0+20 wraps to 0010
        issue(4'd6, 16'h8040, 8'h00, 8'hFF, "R6");   // 1200+FF
        issue(4'd7, 16'h8050, 8'h0F, 8'h00, "R7");   // pointer FF, high from 00
        issue(4'd7, 16'h7777, 8'h93, 8'h00, "R7");
        issue(4'd8, 16'h8060, 8'h00, 8'h20, "R8");   // FFF0+20 wraps
        issue(4'd8, 16'h8061, 8'h00, 8'h01, "R8");   // pointer FF wraps to 00
        issue(4'd9, 16'h8000, 8'h00, 8'h00, "R9");   // no-operand code
        issue(4'd12, 16'h8000, 8'h00, 8'h00, "R9");
        issue(4'd15, 16'h8000, 8'h00, 8'h00, "R9");

        // R10: inputs change and start pulses while busy
        @(negedge clk);
        start = 1'b1; mode_code = 4'd5; opnd_addr = 16'h8030; idx_x = 8'h20; idx_y = 8'h00;
        s = cyc;
        sched(s, 4'd5, 16'h8030, 8'h20, 8'h00, "R10", len);
        @(negedge clk);
        start = 1'b0; mode_code = 4'd0; idx_x = 8'hFF; opnd_addr = 16'h0000;
        @(negedge clk);
        start = 1'b1;                      // ignored, unit busy
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; mode_code = 4'd9;    // in the done cycle: ignored
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);

        issue(4'd2, 16'h8010, 8'h01, 8'h00, "R4");   // back to normal service

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule